// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller that sits on an APB slave port. It serves up to four ports of pins. Each port has an output-value register, an output-enable (direction) register and a read-only view of the synchronised pin levels. The first port (port 0) also has per-bit interrupt logic. For each of its pins, software chooses enable, mask, edge or level sensing, polarity, and an optional debounce filter. The unmasked pending bits are combined into one interrupt line.

Pending edge events are held in a latch until software writes ones to the acknowledge register. Level events follow the live pin and stay pending while the level is active. The block has no hardware mode that triggers on both edges. To get that behaviour, software flips the polarity bit after each event. A build-time parameter chooses between two address layouts for the interrupt registers. The debounce filter samples on a strobe, `dbnc_tick`, which the chip supplies from a slow clock divider.

APB has its own handshake, so the block adds no valid/ready layer. Every transfer completes in its access phase: `pready` stays high and `pslverr` stays low. Back-pressure is therefore never applied.

Top module: `apb_gpio_ctrl`

## Requirements
- R1: Port p has its output value at byte offset 12·p and its output enable at 12·p+4. These registers drive `pins_out` and `pins_oe` in slice [32p+31:32p] from the clock edge that ends the write access phase. Both registers reset to zero.
- R2: Reading offset 0x50+4·p returns the pin levels of port p after two clock edges of synchronisation, whatever the direction setting. Writing to those offsets changes nothing.
- R3: `pready` is always 1 and `pslverr` always 0. A write takes effect on the edge where `psel`, `penable` and `pwrite` are all high. Reads of unmapped offsets, and of the acknowledge register, return 0.
- R4: For a port-0 bit, a sense bit of 1 selects edge mode. In edge mode, a polarity bit of 1 latches the pending bit on a rising edge and a polarity bit of 0 latches it on a falling edge. The latched bit stays set after the pin returns to its old level.
- R5: A sense bit of 0 selects level mode. In level mode the pending bit follows the live pin: high when polarity is 1, low when polarity is 0. Writing the acknowledge register has no effect on a level bit.
- R6: A bit whose enable is 0 never becomes pending. A bit whose mask is 1 reads 0 in the status register and does not drive `irq`. A latched edge still reappears once the mask is cleared.
- R7: Writing 1 to a bit of the acknowledge register clears that bit's latched edge. Bits written 0 are left alone. If a new edge is latched on the same edge as the acknowledge, the bit stays set.
- R8: `irq` is high exactly when some bit of the masked status is high.
- R9: When a bit's debounce enable is 1, a new level on that pin is used for interrupts only after three consecutive `dbnc_tick` samples have seen it. Shorter pulses are dropped.
- R10: Default layout offsets are: enable 0x30, mask 0x34, sense 0x38, polarity 0x3C, status 0x40, debounce 0x48, acknowledge 0x4C. With `ALT_LAYOUT`=1 the offsets become: mask 0x44, sense 0x34, polarity 0x38, status 0x3C, acknowledge 0x40. Every other offset stays the same.
- R11: Pins of ports 1 to 3 never set a pending bit or drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pins_in | input | NUM_PORTS*PORT_W | Pin levels from pads |
| pins_out | output | NUM_PORTS*PORT_W | Output values to pads |
| pins_oe | output | NUM_PORTS*PORT_W | Output enables to pads |
| dbnc_tick | input | 1 | Debounce sampling strobe |
| irq | output | 1 | Combined interrupt |

## Verification
An acknowledge write can land on the same clock edge that latches a fresh edge on the same bit.

The bench provokes this collision by changing a port-0 pin and then starting an APB write to the acknowledge register at once. The write's access phase then ends on the third edge after the pin change, which is the edge where the synchronised edge is latched. The bench judges the result by reading the status afterwards and expecting the bit still set.

A behavioural model, stepped on every clock, also compares `irq`, the pin outputs and every read value, so any disagreement in that cycle shows up at once.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int PORT_STRIDE = 12;
  localparam int DIR_OFS     = 4;
  localparam int EXT_BASE    = 'h50;
  localparam int EXT_STRIDE  = 4;
  localparam int MAX_PORTS   = 4;

  typedef enum logic [3:0] {
    REG_NONE, REG_OUT, REG_DIR, REG_EXT, REG_EN, REG_MASK,
    REG_SENSE, REG_POL, REG_STAT, REG_DEB, REG_ACK
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  port;
  } reg_sel_t;

  function automatic reg_sel_t gpio_decode(input logic [31:0] a, input bit alt,
                                           input int nports);
    reg_sel_t r;
    r.kind = REG_NONE;
    r.port = '0;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (p < nports) begin
        if (a == 32'(p * PORT_STRIDE)) begin
          r.kind = REG_OUT; r.port = 2'(p);
        end
        if (a == 32'(p * PORT_STRIDE + DIR_OFS)) begin
          r.kind = REG_DIR; r.port = 2'(p);
        end
        if (a == 32'(EXT_BASE + p * EXT_STRIDE)) begin
          r.kind = REG_EXT; r.port = 2'(p);
        end
      end
    end
    if (a == 32'h30) r.kind = REG_EN;
    if (a == 32'h48) r.kind = REG_DEB;
    if (!alt) begin
      case (a)
        32'h34:  r.kind = REG_MASK;
        32'h38:  r.kind = REG_SENSE;
        32'h3c:  r.kind = REG_POL;
        32'h40:  r.kind = REG_STAT;
        32'h4c:  r.kind = REG_ACK;
        default: ;
      endcase
    end else begin
      case (a)
        32'h44:  r.kind = REG_MASK;
        32'h34:  r.kind = REG_SENSE;
        32'h38:  r.kind = REG_POL;
        32'h3c:  r.kind = REG_STAT;
        32'h40:  r.kind = REG_ACK;
        default: ;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W    = 32,
  parameter int HOLD = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;
    logic             filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else if (!en[b]) begin
        // filter off: track the input so enabling it causes no glitch
        filt_q <= d[b];
        cnt_q  <= '0;
      end else if (tick) begin
        if (d[b] != filt_q) begin
          if (cnt_q == LAST) begin
            filt_q <= d[b];
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end

    assign q[b] = en[b] ? filt_q : d[b];
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ack,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q, latch_q;
  logic [W-1:0] rise, fall, hit, lvl_act;

  assign rise    = level & ~prev_q;
  assign fall    = ~level & prev_q;
  assign hit     = en & edge_sel & ((pol & rise) | (~pol & fall));
  assign lvl_act = en & ~edge_sel & ~(level ^ pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= level;
      // a new edge wins over a same-cycle acknowledge
      latch_q <= (latch_q & ~ack) | hit;
    end
  end

  assign status = ((latch_q & en & edge_sel) | lvl_act) & ~mask;
  assign irq    = |status;
endmodule

// File: rtl/apb_gpio_ctrl.sv
module apb_gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_W     = 32,
  parameter int ADDR_W     = 8,
  parameter bit ALT_LAYOUT = 1'b0,
  parameter int DB_HOLD    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_in,
  output logic [NUM_PORTS*PORT_W-1:0] pins_out,
  output logic [NUM_PORTS*PORT_W-1:0] pins_oe,
  input  logic                        dbnc_tick,
  output logic                        irq
);
  localparam int BUS_W = NUM_PORTS * PORT_W;

  reg_sel_t            sel;
  logic                wr_en;
  logic [PORT_W-1:0]   wdat;
  logic [PORT_W-1:0]   out_q [NUM_PORTS];
  logic [PORT_W-1:0]   dir_q [NUM_PORTS];
  logic [PORT_W-1:0]   en_q, mask_q, sense_q, pol_q, deb_q;
  logic [PORT_W-1:0]   ack_pulse, pa_level, stat, rd_val;
  logic [BUS_W-1:0]    pins_s;

  assign sel     = gpio_decode(32'(paddr), ALT_LAYOUT, NUM_PORTS);
  assign wr_en   = psel & penable & pwrite;
  assign wdat    = pwdata[PORT_W-1:0];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[p] <= '0;
        dir_q[p] <= '0;
      end else if (wr_en && sel.port == 2'(p)) begin
        if (sel.kind == REG_OUT) out_q[p] <= wdat;
        if (sel.kind == REG_DIR) dir_q[p] <= wdat;
      end
    end
    assign pins_out[p*PORT_W +: PORT_W] = out_q[p];
    assign pins_oe[p*PORT_W +: PORT_W]  = dir_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      deb_q   <= '0;
    end else if (wr_en) begin
      case (sel.kind)
        REG_EN:    en_q    <= wdat;
        REG_MASK:  mask_q  <= wdat;
        REG_SENSE: sense_q <= wdat;
        REG_POL:   pol_q   <= wdat;
        REG_DEB:   deb_q   <= wdat;
        default:   ;
      endcase
    end
  end

  assign ack_pulse = (wr_en && sel.kind == REG_ACK) ? wdat : '0;

  gpio_sync #(.W(BUS_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_in), .q(pins_s)
  );

  gpio_debounce #(.W(PORT_W), .HOLD(DB_HOLD)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(dbnc_tick), .en(deb_q),
    .d(pins_s[PORT_W-1:0]), .q(pa_level)
  );

  gpio_irq #(.W(PORT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .level(pa_level), .en(en_q), .mask(mask_q),
    .edge_sel(sense_q), .pol(pol_q), .ack(ack_pulse), .status(stat), .irq(irq)
  );

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      REG_EN:    rd_val = en_q;
      REG_MASK:  rd_val = mask_q;
      REG_SENSE: rd_val = sense_q;
      REG_POL:   rd_val = pol_q;
      REG_DEB:   rd_val = deb_q;
      REG_STAT:  rd_val = stat;
      default:   ;
    endcase
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel.port == 2'(p)) begin
        if (sel.kind == REG_OUT) rd_val = out_q[p];
        if (sel.kind == REG_DIR) rd_val = dir_q[p];
        if (sel.kind == REG_EXT) rd_val = pins_s[p*PORT_W +: PORT_W];
      end
    end
  end

  assign prdata = 32'(rd_val);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        psel,
  input logic                        penable,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [31:0]                 pwdata,
  input logic                        pready,
  input logic                        pslverr,
  input logic [NUM_PORTS*PORT_W-1:0] pins_out,
  input logic [NUM_PORTS*PORT_W-1:0] pins_oe,
  input logic                        irq,
  input logic [PORT_W-1:0]           int_en,
  input logic [PORT_W-1:0]           int_mask
);
  logic wr;
  assign wr = psel && penable && pwrite;

  assert_apb_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  assert_out_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == '0) |=> pins_out[PORT_W-1:0] == $past(pwdata[PORT_W-1:0]));

  assert_ext_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'('h50)) |=> ($stable(pins_out) && $stable(pins_oe)));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);

  assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&int_mask) |-> !irq);
endmodule

bind apb_gpio_ctrl gpio_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq),
  .int_en(en_q), .int_mask(mask_q)
);

// File: tb/apb_gpio_ctrl_tb_top.sv
module apb_gpio_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         psel = 1'b0, psel_alt = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]   paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata, prdata_alt;
  logic         pready, pslverr, pready_alt, pslverr_alt;
  logic [127:0] pins_in = '0;
  logic [127:0] pins_out, pins_oe, pout_alt, poe_alt;
  logic         tick = 1'b0;
  logic         irq, irq_alt;
  int           checks = 0, errors = 0, tcnt = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  apb_gpio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe),
    .dbnc_tick(tick), .irq(irq)
  );

  apb_gpio_ctrl #(.ALT_LAYOUT(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .psel(psel_alt), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_alt), .pready(pready_alt),
    .pslverr(pslverr_alt), .pins_in(128'd0), .pins_out(pout_alt), .pins_oe(poe_alt),
    .dbnc_tick(tick), .irq(irq_alt)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0]  m_out [4], m_dir [4];
  logic [31:0]  m_en = 0, m_mask = 0, m_sense = 0, m_pol = 0, m_deb = 0;
  logic [31:0]  m_pend = 0, m_prev = 0, m_filt = 0;
  int           m_run [32];
  logic [127:0] m_seen1 = 0, m_seen2 = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_dir[i] = 0; end
    for (int i = 0; i < 32; i++) m_run[i] = 0;
  end

  function automatic logic [31:0] m_level();
    logic [31:0] v;
    for (int b = 0; b < 32; b++) v[b] = m_deb[b] ? m_filt[b] : m_seen2[b];
    return v;
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] lv, act;
    lv  = m_level();
    act = m_en & ~m_sense & ~(lv ^ m_pol);
    return ((m_pend & m_en & m_sense) | act) & ~m_mask;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    for (int p = 0; p < 4; p++) begin
      if (a == 8'(12 * p))     return m_out[p];
      if (a == 8'(12 * p + 4)) return m_dir[p];
      if (a == 8'('h50 + 4 * p)) return m_seen2[32*p +: 32];
    end
    case (a)
      8'h30: return m_en;
      8'h34: return m_mask;
      8'h38: return m_sense;
      8'h3c: return m_pol;
      8'h40: return m_status();
      8'h48: return m_deb;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a >= 8'h50 && a <= 8'h5c) return "R2";
    if (a < 8'h30) return "R1";
    if (a == 8'h40) return "R4";
    if (a == 8'h48) return "R9";
    if (a >= 8'h30 && a <= 8'h3c) return "R10";
    return "R3";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_dir[i] = 0; end
      for (int i = 0; i < 32; i++) m_run[i] = 0;
      m_en = 0; m_mask = 0; m_sense = 0; m_pol = 0; m_deb = 0;
      m_pend = 0; m_prev = 0; m_filt = 0; m_seen1 = 0; m_seen2 = 0;
    end else begin
      logic [31:0] lv, hits, ack;
      bit wr;
      wr   = psel && penable && pwrite;
      lv   = m_level();
      hits = 0;
      for (int b = 0; b < 32; b++)
        if (m_en[b] && m_sense[b] && (lv[b] != m_prev[b]) && (lv[b] == m_pol[b]))
          hits[b] = 1'b1;
      ack    = (wr && paddr == 8'h4c) ? pwdata : 32'h0;
      m_pend = (m_pend & ~ack) | hits;
      for (int b = 0; b < 32; b++) begin
        if (!m_deb[b]) begin
          m_filt[b] = m_seen2[b]; m_run[b] = 0;
        end else if (tick) begin
          if (m_seen2[b] != m_filt[b]) begin
            m_run[b]++;
            if (m_run[b] >= 3) begin m_filt[b] = m_seen2[b]; m_run[b] = 0; end
          end else m_run[b] = 0;
        end
      end
      m_prev  = lv;
      m_seen2 = m_seen1;
      m_seen1 = pins_in;
      if (wr) begin
        for (int p = 0; p < 4; p++) begin
          if (paddr == 8'(12 * p))     m_out[p] = pwdata;
          if (paddr == 8'(12 * p + 4)) m_dir[p] = pwdata;
        end
        case (paddr)
          8'h30: m_en = pwdata;
          8'h34: m_mask = pwdata;
          8'h38: m_sense = pwdata;
          8'h3c: m_pol = pwdata;
          8'h48: m_deb = pwdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [127:0] eo, ed;
      for (int p = 0; p < 4; p++) begin
        eo[32*p +: 32] = m_out[p];
        ed[32*p +: 32] = m_dir[p];
      end
      chk("R8", "irq", {127'd0, irq}, {127'd0, |m_status()});
      chk("R1", "pins_out", pins_out, eo);
      chk("R1", "pins_oe", pins_oe, ed);
      chk("R3", "pready/pslverr", {126'd0, pready, pslverr}, {126'd0, 2'b10});
      if (psel && penable && !pwrite)
        chk(tag_of(paddr), "prdata", {96'd0, prdata}, {96'd0, m_read(paddr)});
    end
  end

  initial forever begin
    @(posedge clk); #2;
    tcnt++;
    tick = (tcnt % 4 == 0);
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, input bit alt = 0);
    @(posedge clk); #2;
    if (alt) psel_alt = 1'b1; else psel = 1'b1;
    pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #2;
    penable = 1'b1;
    @(posedge clk); #2;
    psel = 1'b0; psel_alt = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd_chk(input logic [7:0] a, input logic [31:0] exp,
                            input string tag, input bit alt = 0);
    logic [31:0] v;
    @(posedge clk); #2;
    if (alt) psel_alt = 1'b1; else psel = 1'b1;
    pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); #2;
    penable = 1'b1;
    @(negedge clk);
    v = alt ? prdata_alt : prdata;
    chk(tag, $sformatf("read 0x%02h", a), {96'd0, v}, {96'd0, exp});
    @(posedge clk); #2;
    psel = 1'b0; psel_alt = 1'b0; penable = 1'b0;
  endtask

  task automatic set_pa(input int bitn, input logic v);
    @(posedge clk); #2;
    pins_in[bitn] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset pins_out", pins_out, 128'd0);
    chk("R1", "reset pins_oe", pins_oe, 128'd0);
    chk("R8", "reset irq", {127'd0, irq}, 128'd0);
    apb_rd_chk(8'h00, 32'h0, "R1");

    // R1 output registers on several ports
    apb_wr(8'h00, 32'hDEADBEEF);
    apb_wr(8'h04, 32'hFFFF0000);
    apb_wr(8'h0c, 32'h12345678);
    apb_wr(8'h28, 32'h0F0F0F0F);
    @(negedge clk);
    chk("R1", "port0 out", {96'd0, pins_out[31:0]}, {96'd0, 32'hDEADBEEF});
    chk("R1", "port1 out", {96'd0, pins_out[63:32]}, {96'd0, 32'h12345678});
    chk("R1", "port3 oe", {96'd0, pins_oe[127:96]}, {96'd0, 32'h0F0F0F0F});
    apb_rd_chk(8'h10, 32'h0, "R1");
    apb_rd_chk(8'h04, 32'hFFFF0000, "R1");

    // R2 pin readback, regardless of direction; writes ignored
    @(posedge clk); #2;
    pins_in = {32'hD0D0D0D0, 32'hC0C0C0C0, 32'hB0B0B0B0, 32'h0};
    idle(3);
    apb_rd_chk(8'h54, 32'hB0B0B0B0, "R2");
    apb_rd_chk(8'h5c, 32'hD0D0D0D0, "R2");
    apb_wr(8'h50, 32'hFFFFFFFF);
    apb_rd_chk(8'h50, 32'h0, "R2");
    apb_rd_chk(8'h00, 32'hDEADBEEF, "R2");

    // R3 unmapped and write-only offsets read as zero
    apb_rd_chk(8'h60, 32'h0, "R3");
    apb_rd_chk(8'h44, 32'h0, "R3");
    apb_rd_chk(8'h4c, 32'h0, "R3");

    // R4 edge mode, R8 irq, R7 acknowledge
    apb_wr(8'h38, 32'h3);
    apb_wr(8'h3c, 32'h1);
    apb_wr(8'h30, 32'h3);
    apb_rd_chk(8'h40, 32'h0, "R4");
    set_pa(0, 1'b1); idle(4);
    apb_rd_chk(8'h40, 32'h1, "R4");
    @(negedge clk); chk("R8", "irq on edge", {127'd0, irq}, {127'd0, 1'b1});
    set_pa(0, 1'b0); idle(4);
    apb_rd_chk(8'h40, 32'h1, "R4");
    apb_wr(8'h4c, 32'h1);
    apb_rd_chk(8'h40, 32'h0, "R7");
    @(negedge clk); chk("R8", "irq after ack", {127'd0, irq}, 128'd0);
    set_pa(1, 1'b1); idle(4);
    apb_rd_chk(8'h40, 32'h0, "R4");
    set_pa(1, 1'b0); idle(4);
    apb_rd_chk(8'h40, 32'h2, "R4");
    apb_wr(8'h4c, 32'h1);
    apb_rd_chk(8'h40, 32'h2, "R7");
    apb_wr(8'h4c, 32'h2);
    apb_rd_chk(8'h40, 32'h0, "R7");

    // R5 level mode, active low on bit 2
    apb_wr(8'h30, 32'h7);
    apb_rd_chk(8'h40, 32'h4, "R5");
    apb_wr(8'h4c, 32'h4);
    apb_rd_chk(8'h40, 32'h4, "R5");
    set_pa(2, 1'b1); idle(4);
    apb_rd_chk(8'h40, 32'h0, "R5");

    // R6 mask hides a latched edge, enable gates it
    apb_wr(8'h34, 32'h1);
    set_pa(0, 1'b1); idle(4);
    apb_rd_chk(8'h40, 32'h0, "R6");
    @(negedge clk); chk("R6", "masked irq", {127'd0, irq}, 128'd0);
    apb_wr(8'h34, 32'h0);
    apb_rd_chk(8'h40, 32'h1, "R6");
    apb_wr(8'h4c, 32'h1);
    set_pa(0, 1'b0); idle(4);
    apb_wr(8'h38, 32'hB);
    apb_wr(8'h3c, 32'h9);
    set_pa(3, 1'b1); idle(4);
    apb_rd_chk(8'h40, 32'h0, "R6");
    set_pa(3, 1'b0); idle(4);

    // R7 acknowledge on the same edge a new edge latches
    @(posedge clk); #2;
    pins_in[0] = 1'b1;
    apb_wr(8'h4c, 32'h1);
    apb_rd_chk(8'h40, 32'h1, "R7");
    apb_wr(8'h4c, 32'h1);
    apb_rd_chk(8'h40, 32'h0, "R7");
    set_pa(0, 1'b0); idle(4);

    // R11 other ports do not interrupt
    @(posedge clk); #2;
    pins_in[63:32] = 32'hFFFFFFFF;
    idle(4);
    @(posedge clk); #2;
    pins_in[63:32] = 32'h0;
    idle(4);
    apb_rd_chk(8'h40, 32'h0, "R11");
    @(negedge clk); chk("R11", "irq from port1", {127'd0, irq}, 128'd0);

    // R9 debounce on bit 4
    apb_wr(8'h38, 32'h1B);
    apb_wr(8'h3c, 32'h19);
    apb_wr(8'h30, 32'h17);
    apb_wr(8'h48, 32'h10);
    apb_rd_chk(8'h48, 32'h10, "R9");
    set_pa(4, 1'b1); idle(4);
    set_pa(4, 1'b0); idle(20);
    apb_rd_chk(8'h40, 32'h0, "R9");
    set_pa(4, 1'b1); idle(24);
    apb_rd_chk(8'h40, 32'h10, "R9");
    apb_wr(8'h4c, 32'h10);
    apb_rd_chk(8'h40, 32'h0, "R9");

    // R10 alternate register layout
    apb_wr(8'h34, 32'hA5, 1);
    apb_rd_chk(8'h34, 32'hA5, "R10", 1);
    apb_rd_chk(8'h44, 32'h0, "R10", 1);
    apb_wr(8'h44, 32'h3C, 1);
    apb_rd_chk(8'h44, 32'h3C, "R10", 1);
    apb_rd_chk(8'h38, 32'h0, "R10", 1);
    apb_rd_chk(8'h3c, 32'h0, "R10", 1);
    apb_rd_chk(8'h34, 32'h0, "R10");

    idle(2);
    finish_run();
  end
endmodule